// File: doc/BRIEF.md
# Eight-Channel Trigger Prescaler

This block thins out trigger traffic so that a downstream acquisition system is not flooded. Each of eight independent trigger lines arrives as an asynchronous level. The block brings each line into the clock domain and detects its rising edges. Each channel then has its own counter that lets through one edge out of every N, where N is a 16-bit factor held per channel. A passed edge appears as a single-cycle pulse on that channel's output.

A simple single-port register interface sets the block up. The registers are a per-channel enable mask, the eight factors, a write-only strobe that returns every counter to zero, and a write-only strobe that zeroes every factor. The intended bring-up order is:

1. Disable all channels.
2. Clear the factors.
3. Load new factors.
4. Reset the counters.
5. Write the final enable mask.

After step 5 each channel starts from a known count. The trigger lines are plain levels and the outputs are plain pulses. The block applies no back-pressure.

Top module: `trig_prescaler`

## Requirements
- R1: After reset, the enable mask and all factors read as 0, and no output pulse occurs.
- R2: With factor N (N ≥ 1) and the channel enabled, the channel outputs a pulse on the Nth, 2Nth, 3Nth, … rising edge counted since the last counter reset.
- R3: A factor of 1 passes every rising edge of an enabled channel.
- R4: A factor of 0 blocks the channel completely, and its counter does not advance.
- R5: While its enable bit (bit n of the enable register is channel n, 1 = enabled) is 0, a channel outputs nothing and its counter holds its value.
- R6: A write of any data to address 0x12 returns every channel counter to 0. The enables and the factors are left unchanged.
- R7: A write of any data to address 0x14 sets every factor to 0. The enable mask is left unchanged.
- R8: The enable mask is read and written at address 0x10 in bits 7:0, and bits 15:8 read as 0. The factor of channel n is read and written at address 0x20+2n. Any other read address returns 0.
- R9: Suppose an input is first sampled high at clock edge k after being low. If that edge is passed, the output is high for exactly the one cycle that follows edge k+2.
- R10: An input held high for many cycles counts as one edge only.
- R11: Channels are independent. Edges, factors and enables of one channel never affect another channel's output.
- R12: If a factor is lowered to a value at or below the current count, the next counted edge of that channel passes and the counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | Asynchronous trigger levels, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Combinational read data for rd_addr |
| trig_out | output | 8 | One-cycle prescaled trigger pulses, one bit per channel |

## Verification
The bench targets the following corner cases and the faulty behaviour each one would reveal:

- **Factor 0 and a disabled channel.** A design that still counted in either case would let a pulse out early once the channel was re-enabled.
- **A long high level.** A missing edge detector would emit a pulse on every cycle of the level.
- **The counter reset strobe issued mid-count.** A design that ignored the strobe would fire one or two edges too soon after it.
- **Lowering a factor below the current count.** An equality compare would let the counter run on to its wrap before firing.

Random traffic with random factors and masks is compared against a counting model to expose any coupling between channels. The exact three-cycle latency is also pinned.

// File: rtl/trig_prescaler_pkg.sv
package trig_prescaler_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_ENABLE      = 8'h10;
  localparam logic [ADDR_W-1:0] A_CNT_RESET   = 8'h12;
  localparam logic [ADDR_W-1:0] A_FAC_CLEAR   = 8'h14;
  localparam logic [ADDR_W-1:0] A_FACTOR_BASE = 8'h20;

  function automatic logic [ADDR_W-1:0] factor_addr(input int ch);
    return A_FACTOR_BASE + ADDR_W'(2 * ch);
  endfunction
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl_i,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= lvl_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;

  // R10: a rising edge flag never lasts two cycles on the same channel
  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/trig_prescaler_regs.sv
module trig_prescaler_regs
  import trig_prescaler_pkg::*;
#(
  parameter int NCH = 8,
  parameter int FW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [FW-1:0]           wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [FW-1:0]           rd_data,
  output logic [NCH-1:0]          enable_o,
  output logic [NCH-1:0][FW-1:0]  factor_o,
  output logic                    cnt_reset_o
);
  logic fac_clear;

  assign cnt_reset_o = wr_en && (wr_addr == A_CNT_RESET);
  assign fac_clear   = wr_en && (wr_addr == A_FAC_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_o <= '0;
    else if (wr_en && wr_addr == A_ENABLE)
      enable_o <= wr_data[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_fac
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        factor_o[g] <= '0;
      else if (fac_clear)
        factor_o[g] <= '0;
      else if (wr_en && wr_addr == factor_addr(g))
        factor_o[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_ENABLE)
      rd_data = FW'(enable_o);
    for (int i = 0; i < NCH; i++)
      if (rd_addr == factor_addr(i))
        rd_data = factor_o[i];
  end

  // R7: clear strobe leaves every factor at zero
  p_clear_zeros_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fac_clear |=> (factor_o == '0));
  // R7: clear strobe leaves the enable mask unchanged
  p_clear_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fac_clear |=> $stable(enable_o));
endmodule

// File: rtl/trig_chan_counter.sv
module trig_chan_counter #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          en_i,
  input  logic [FW-1:0] factor_i,
  input  logic          cnt_reset_i,
  output logic          pulse_o
);
  logic [FW-1:0] cnt_q;
  logic [FW:0]   cnt_next;
  logic          counting;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign counting = edge_i && en_i && (factor_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (cnt_reset_i) begin
        cnt_q <= '0;
      end else if (counting) begin
        if (cnt_next >= {1'b0, factor_i}) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_next[FW-1:0];
        end
      end
    end
  end

  // R5: a pulse only follows a cycle in which the channel was enabled
  p_pulse_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(en_i));
  // R5: a disabled channel holds its count
  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_reset_i) |=> $stable(cnt_q));
  // R4: a zero factor never lets a pulse out
  p_zero_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> ($past(factor_i) != '0));
  // R6: counter reset wins and leaves the count at zero without a pulse
  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reset_i |=> (cnt_q == '0 && !pulse_o));
  // R9: pulses are one cycle wide
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler
  import trig_prescaler_pkg::*;
#(
  parameter int NCH = 8,
  parameter int FW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    trig_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [FW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [FW-1:0]     rd_data,
  output logic [NCH-1:0]    trig_out
);
  logic [NCH-1:0]         rise;
  logic [NCH-1:0]         enable;
  logic [NCH-1:0][FW-1:0] factor;
  logic                   cnt_reset;

  trig_sync_edge #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_i(trig_in), .rise_o(rise)
  );

  trig_prescaler_regs #(.NCH(NCH), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .enable_o(enable), .factor_o(factor), .cnt_reset_o(cnt_reset)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    trig_chan_counter #(.FW(FW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .edge_i(rise[g]), .en_i(enable[g]),
      .factor_i(factor[g]), .cnt_reset_i(cnt_reset), .pulse_o(trig_out[g])
    );
  end

  // R9: an output pulse always traces back to an input edge two cycles earlier
  p_pulse_from_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out != '0) |-> ((trig_out & ~$past(rise)) == '0));
endmodule

// File: tb/trig_prescaler_tb_top.sv
module trig_prescaler_tb_top;
  localparam int NCH = 8;
  localparam int FW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    trig_in = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [15:0]   rd_data;
  logic [7:0]    trig_out;

  always #2 clk = ~clk;

  trig_prescaler #(.NCH(NCH), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .trig_out(trig_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int got [NCH];
  int expc[NCH];
  int mcnt[NCH];
  int mfac[NCH];
  logic [7:0] men = '0;
  bit done = 0;

  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i < NCH; i++) got[i] += int'(trig_out[i]);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic zero_tallies();
    for (int i = 0; i < NCH; i++) begin got[i] = 0; expc[i] = 0; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h10) men = d[7:0];
    else if (a == 8'h12) for (int i = 0; i < NCH; i++) mcnt[i] = 0;
    else if (a == 8'h14) for (int i = 0; i < NCH; i++) mfac[i] = 0;
    else for (int i = 0; i < NCH; i++) if (a == 8'h20 + 8'(2*i)) mfac[i] = int'(d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(int'(rd_data) == exp, req, int'(rd_data), exp);
  endtask

  task automatic edges(input logic [7:0] mask, input int n, input int hold);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      trig_in = mask;
      repeat (hold) @(negedge clk);
      trig_in = '0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NCH; i++)
        if (mask[i] && men[i] && mfac[i] != 0) begin
          mcnt[i]++;
          if (mcnt[i] >= mfac[i]) begin expc[i]++; mcnt[i] = 0; end
        end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_ch(input int ch, input int exp, input string req);
    chk(got[ch] == exp, req, got[ch], exp);
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < NCH; i++) chk(got[i] == expc[i], req, got[i], expc[i]);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin mcnt[i] = 0; mfac[i] = 0; got[i] = 0; expc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(trig_out == 8'h00, "R1 outputs", int'(trig_out), 0);
    rd_chk(8'h10, 0, "R1 enable");
    rd_chk(8'h26, 0, "R1 factor");
    edges(8'hFF, 2, 2);
    cmp_all("R1 no pulses");

    // R8 register map
    for (int i = 0; i < NCH; i++) wr(8'h20 + 8'(2*i), 16'(i*1000 + 7));
    for (int i = 0; i < NCH; i++) rd_chk(8'h20 + 8'(2*i), i*1000 + 7, "R8 factor readback");
    wr(8'h10, 16'hFFA5);
    rd_chk(8'h10, 16'h00A5, "R8 enable readback");
    rd_chk(8'h12, 0, "R8 unmapped");
    rd_chk(8'h21, 0, "R8 odd addr");
    rd_chk(8'h30, 0, "R8 past end");

    // R9 latency with factor 1 on channel 0
    wr(8'h10, 16'h0000); wr(8'h14, 0);
    wr(8'h20, 16'd1); wr(8'h12, 0); wr(8'h10, 16'h0001);
    @(negedge clk); trig_in = 8'h01;
    @(negedge clk); chk(trig_out[0] == 1'b0, "R9 early A", int'(trig_out[0]), 0);
    @(negedge clk); chk(trig_out[0] == 1'b0, "R9 early B", int'(trig_out[0]), 0);
    @(negedge clk); chk(trig_out[0] == 1'b1, "R9 pulse", int'(trig_out[0]), 1);
    @(negedge clk); chk(trig_out[0] == 1'b0, "R9 one cycle", int'(trig_out[0]), 0);
    trig_in = '0; repeat (4) @(negedge clk);
    zero_tallies();

    // R2, R3, R4, R10
    wr(8'h22, 16'd0); wr(8'h24, 16'd3); wr(8'h12, 0); wr(8'h10, 16'h0007);
    edges(8'h07, 7, 2);
    cmp_ch(0, 7, "R3 every edge");
    cmp_ch(1, 0, "R4 factor zero");
    cmp_ch(2, 2, "R2 factor 3 over 7 edges");
    zero_tallies();
    edges(8'h01, 1, 20);
    cmp_ch(0, 1, "R10 long level");

    // R5 disabled channel holds its count
    zero_tallies();
    wr(8'h12, 0); wr(8'h10, 16'h0000);
    edges(8'h04, 5, 2);
    cmp_ch(2, 0, "R5 disabled silent");
    wr(8'h10, 16'h0004);
    edges(8'h04, 2, 2);
    cmp_ch(2, 0, "R5 no early pulse");
    edges(8'h04, 1, 2);
    cmp_ch(2, 1, "R5 third edge after enable");

    // R6 counter reset mid-count
    zero_tallies();
    edges(8'h04, 2, 2);
    wr(8'h12, 0);
    edges(8'h04, 2, 2);
    cmp_ch(2, 0, "R6 reset restarts count");
    edges(8'h04, 1, 2);
    cmp_ch(2, 1, "R6 pulse after full count");
    rd_chk(8'h24, 3, "R6 factor kept");

    // R12 lowering the factor
    zero_tallies();
    wr(8'h24, 16'd5); wr(8'h12, 0);
    edges(8'h04, 3, 2);
    wr(8'h24, 16'd2);
    edges(8'h04, 1, 2);
    cmp_ch(2, 1, "R12 lowered factor fires");

    // R7 clear
    zero_tallies();
    wr(8'h14, 0);
    rd_chk(8'h20, 0, "R7 factor0 cleared");
    rd_chk(8'h24, 0, "R7 factor2 cleared");
    rd_chk(8'h10, 4, "R7 enable kept");
    edges(8'h04, 4, 2);
    cmp_ch(2, 0, "R7 cleared blocks");

    // R11 random traffic against the model
    wr(8'h12, 0);
    for (int it = 0; it < 120; it++) begin
      zero_tallies();
      if (it % 10 == 0) begin
        wr(8'h10, 16'h0000); wr(8'h14, 0);
        for (int i = 0; i < NCH; i++) wr(8'h20 + 8'(2*i), 16'($urandom_range(0, 5)));
        wr(8'h12, 0);
        wr(8'h10, 16'($urandom_range(0, 255)));
      end
      edges(8'($urandom_range(0, 255)), $urandom_range(1, 4), $urandom_range(1, 4));
      cmp_all("R11 random independent");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule